// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block divides an oscillator-rate clock into the machine cycle of a small 8-bit controller core. A machine cycle has six states, and each state has two phases. Each phase lasts one clock, so a machine cycle lasts twelve clocks. From its position in the cycle the block drives these outputs:

- the current state number and phase;
- the address latch enable pulse;
- the active-low external program read strobe;
- two code-fetch strobes;
- a program-counter increment enable;
- an end-of-cycle pulse;
- an active-low data transfer strobe.

The surrounding core tells the block three things: whether program memory is external, whether the instruction needs the code byte of the second fetch, and whether the instruction performs an external data transfer.

Each normal machine cycle makes two code fetches. If the second byte is not needed, the second fetch still happens, but the program counter is not advanced. Internal program memory keeps the read strobe idle, and the address latch enable keeps pulsing twice per cycle. An external data transfer takes two machine cycles:

- In the first cycle, the late read-strobe window is dropped.
- In the second cycle, there are no fetches, the first latch-enable pulse is dropped, the early read-strobe window is dropped, and the data strobe is active.

Top module: `mcyc_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, the block sits at state 1 phase 1. In that position `state_idx`=1, `phase2`=0, `ale`=0, `psen_n`=1, `xstb_n`=1, and `fetch_op`, `fetch_nxt`, `pc_inc` and `cyc_end` are 0.
- R2: The position advances once per clock through twelve slots. Slot k (0..11) shows `state_idx` = k/2+1 and `phase2` = k mod 2, then wraps to slot 0. The same sequence runs whatever the value of `ext_prog`.
- R3: `cyc_end` is 1 exactly in slot 11 (state 6, phase 2).
- R4: `ale` is 1 in slots 1 and 7 and 0 elsewhere. The exception is slot 1 of the second cycle of a data transfer, where `ale` is 0. This holds for both values of `ext_prog`.
- R5: With `ext_prog`=1, `psen_n` is 0 in two windows: slots 4, 5 and 6, and slots 10 and 11 together with slot 0 of the following cycle. With `ext_prog`=0, `psen_n` stays 1. Slot 0 right after reset is never active.
- R6: `fetch_op` is 1 in slot 1 and `fetch_nxt` is 1 in slot 7, in every cycle except the second cycle of a data transfer.
- R7: `pc_inc` is 1 whenever `fetch_op` is 1. It is also 1 in slot 7 when `fetch_nxt` is 1 and `need_byte` is 1. When `need_byte` is 0 in slot 7, `pc_inc` stays 0 although the fetch still happens.
- R8: `xdata_req` is sampled on the clock that leaves slot 11. A request starts a two-cycle transfer when the ending cycle is not itself the first cycle of a transfer. In the first cycle of the transfer, the slot 10/11/next-slot-0 read window is suppressed. In the second cycle, the slot 4-6 read window, the slot-1 latch pulse and both fetches are suppressed.
- R9: `xstb_n` is 0 in slots 0 to 5 of the second cycle of a data transfer and 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator-rate clock, one phase per period |
| rst | input | 1 | synchronous reset, active high |
| ext_prog | input | 1 | 1 = program memory is external |
| need_byte | input | 1 | current instruction uses the byte of the second fetch |
| xdata_req | input | 1 | request for a two-cycle external data transfer |
| state_idx | output | 3 | current state number, 1..6 |
| phase2 | output | 1 | 0 = first half of the state, 1 = second half |
| ale | output | 1 | address latch enable pulse |
| psen_n | output | 1 | external program read strobe, active low |
| fetch_op | output | 1 | opcode fetch strobe |
| fetch_nxt | output | 1 | second code-byte fetch strobe |
| pc_inc | output | 1 | program counter increment enable |
| cyc_end | output | 1 | end-of-machine-cycle pulse |
| xstb_n | output | 1 | data transfer strobe, active low |

## Verification
The assertions assume a synchronous, glitch-free `xdata_req` that matters only at the edge leaving slot 11. They also assume that `ext_prog` changes only between clocks, so the read-window decode and its carried-over tail see one settled value per slot. The stimulus changes every input only at the falling clock edge. It raises data requests alone, back to back, and during the first cycle of a transfer, where they must be ignored. It toggles `ext_prog` and `need_byte` on random slots, so mode changes also land inside read windows.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int PHASES = 2;

    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_FIRST  = 2'd1,
        XF_SECOND = 2'd2
    } xfer_e;

    function automatic int slot_of(input int state_no, input int phase_no);
        return (state_no - 1) * PHASES + (phase_no - 1);
    endfunction

endpackage

// File: rtl/mcyc_timebase.sv
module mcyc_timebase #(
    parameter int STATES = 6,
    localparam int SLOTS = STATES * mcyc_pkg::PHASES,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == LAST) st_d.slot = '0;
        else                   st_d.slot = st_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slot_o = st_q.slot;
    assign last_o = (st_q.slot == LAST);

    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (slot_o == '0));
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
        !last_o |=> (slot_o == $past(slot_o) + 1'b1));
endmodule

// File: rtl/mcyc_xfer.sv
module mcyc_xfer (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_last,
    input  logic            xdata_req,
    output mcyc_pkg::xfer_e kind_o
);
    import mcyc_pkg::*;

    typedef struct packed {
        xfer_e kind;
    } xf_state_t;

    xf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc_last) begin
            if (st_q.kind == XF_FIRST) st_d.kind = XF_SECOND;
            else if (xdata_req)        st_d.kind = XF_FIRST;
            else                       st_d.kind = XF_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{kind: XF_NONE};
        else     st_q <= st_d;
    end

    assign kind_o = st_q.kind;

    assert_second_follows_first_R8: assert property (@(posedge clk) disable iff (rst)
        (kind_o == XF_SECOND && !$stable(kind_o)) |-> ($past(kind_o) == XF_FIRST));
    assert_kind_holds_in_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(cyc_last) |-> $stable(kind_o));
endmodule

// File: rtl/mcyc_strobe.sv
module mcyc_strobe #(
    parameter int STATES = 6,
    localparam int SLOTS = STATES * mcyc_pkg::PHASES,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot,
    input  mcyc_pkg::xfer_e   kind,
    input  logic              ext_prog,
    input  logic              need_byte,
    output logic              ale,
    output logic              psen_n,
    output logic              fetch_op,
    output logic              fetch_nxt,
    output logic              pc_inc,
    output logic              xstb_n
);
    import mcyc_pkg::*;

    localparam int HALF = STATES / 2;
    localparam logic [SLOT_W-1:0] ADDR1_SLOT = SLOT_W'(slot_of(1, 2));
    localparam logic [SLOT_W-1:0] ADDR2_SLOT = SLOT_W'(slot_of(HALF + 1, 2));
    localparam logic [SLOT_W-1:0] WIN1_LO    = SLOT_W'(slot_of(HALF, 1));
    localparam logic [SLOT_W-1:0] WIN1_HI    = SLOT_W'(slot_of(HALF + 1, 1));
    localparam logic [SLOT_W-1:0] WIN2_LO    = SLOT_W'(slot_of(STATES, 1));
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] XSTB_HI    = SLOT_W'(slot_of(HALF, 2));

    typedef struct packed {
        logic tail;
    } sb_state_t;

    sb_state_t st_d, st_q;
    logic second, first, win_early, win_late, win_head, rd_win;

    always_comb begin
        second    = (kind == XF_SECOND);
        first     = (kind == XF_FIRST);
        win_early = (slot >= WIN1_LO) && (slot <= WIN1_HI) && !second;
        win_late  = (slot >= WIN2_LO) && !first;
        win_head  = (slot == '0) && st_q.tail;
        rd_win    = ext_prog && (win_early || win_late || win_head);

        ale       = (slot == ADDR2_SLOT) || ((slot == ADDR1_SLOT) && !second);
        fetch_op  = (slot == ADDR1_SLOT) && !second;
        fetch_nxt = (slot == ADDR2_SLOT) && !second;
        pc_inc    = fetch_op || (fetch_nxt && need_byte);
        psen_n    = !rd_win;
        xstb_n    = !(second && (slot <= XSTB_HI));

        st_d      = st_q;
        st_d.tail = (slot == LAST_SLOT) && rd_win;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assert_ale_psen_apart_R4: assert property (@(posedge clk) disable iff (rst)
        ale |-> psen_n);
    assert_psen_idle_internal_R5: assert property (@(posedge clk) disable iff (rst)
        !ext_prog |-> psen_n);
    assert_pc_only_on_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        pc_inc |-> (fetch_op || fetch_nxt));
    assert_no_fetch_in_xfer_R9: assert property (@(posedge clk) disable iff (rst)
        !xstb_n |-> !(fetch_op || fetch_nxt || ale));
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq #(
    parameter int STATES = 6,
    localparam int SLOTS = STATES * mcyc_pkg::PHASES,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int STATE_W = $clog2(STATES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_prog,
    input  logic               need_byte,
    input  logic               xdata_req,
    output logic [STATE_W-1:0] state_idx,
    output logic               phase2,
    output logic               ale,
    output logic               psen_n,
    output logic               fetch_op,
    output logic               fetch_nxt,
    output logic               pc_inc,
    output logic               cyc_end,
    output logic               xstb_n
);
    import mcyc_pkg::*;

    logic [SLOT_W-1:0] slot;
    logic              last;
    xfer_e             kind;

    mcyc_timebase #(.STATES(STATES)) u_tb (
        .clk(clk), .rst(rst), .slot_o(slot), .last_o(last)
    );

    mcyc_xfer u_xf (
        .clk(clk), .rst(rst), .cyc_last(last), .xdata_req(xdata_req), .kind_o(kind)
    );

    mcyc_strobe #(.STATES(STATES)) u_sb (
        .clk(clk), .rst(rst), .slot(slot), .kind(kind),
        .ext_prog(ext_prog), .need_byte(need_byte),
        .ale(ale), .psen_n(psen_n), .fetch_op(fetch_op), .fetch_nxt(fetch_nxt),
        .pc_inc(pc_inc), .xstb_n(xstb_n)
    );

    localparam int SLOT_PAD = (SLOT_W > STATE_W) ? SLOT_W : STATE_W;
    logic [SLOT_PAD-1:0] slot_wide;
    assign slot_wide = SLOT_PAD'(slot);
    assign state_idx = STATE_W'(slot_wide >> 1) + STATE_W'(1);
    assign phase2    = slot[0];
    assign cyc_end   = last;

    assert_end_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        cyc_end |=> (!cyc_end && state_idx == STATE_W'(1) && !phase2));
endmodule

// File: tb/mcyc_seq_tb_top.sv
module mcyc_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_prog = 1'b0, need_byte = 1'b0, xdata_req = 1'b0;
    logic [2:0] state_idx;
    logic phase2, ale, psen_n, fetch_op, fetch_nxt, pc_inc, cyc_end, xstb_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mcyc_seq dut_i (
        .clk(clk), .rst(rst), .ext_prog(ext_prog), .need_byte(need_byte),
        .xdata_req(xdata_req), .state_idx(state_idx), .phase2(phase2), .ale(ale),
        .psen_n(psen_n), .fetch_op(fetch_op), .fetch_nxt(fetch_nxt), .pc_inc(pc_inc),
        .cyc_end(cyc_end), .xstb_n(xstb_n)
    );

    // behavioural reference: oscillator count, current cycle kind, carried read window
    int  osc = 0;
    int  kind = 0;       // 0 plain, 1 first of transfer, 2 second of transfer
    bit  carry = 1'b0;

    function automatic bit read_win(input int s, input int k, input bit c, input bit ext);
        bit w;
        w = ((s >= 4 && s <= 6) && k != 2) || (s >= 10 && k != 1) || (s == 0 && c);
        return ext && w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            osc = 0; kind = 0; carry = 1'b0;
        end else begin
            carry = (osc % 12 == 11) && read_win(11, kind, carry, ext_prog);
            if (osc % 12 == 11) kind = (kind == 1) ? 2 : (xdata_req ? 1 : 0);
            osc = osc + 1;
        end
    end

    task automatic cmp(input string req, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at osc %0d", req, name, act, exp, osc);
        end
    endtask

    task automatic check_all(input string rtag);
        int s;
        bit e_ale, e_fop, e_fnx;
        s = osc % 12;
        e_ale = (s == 1 && kind != 2) || s == 7;
        e_fop = (s == 1 && kind != 2);
        e_fnx = (s == 7 && kind != 2);
        cmp({rtag, "/R2"}, "state_idx", int'(state_idx), s / 2 + 1);
        cmp({rtag, "/R2"}, "phase2", int'(phase2), s % 2);
        cmp("R3", "cyc_end", int'(cyc_end), int'(s == 11));
        cmp("R4/R8", "ale", int'(ale), int'(e_ale));
        cmp("R5/R8", "psen_n", int'(psen_n), int'(!read_win(s, kind, carry, ext_prog)));
        cmp("R6", "fetch_op", int'(fetch_op), int'(e_fop));
        cmp("R6", "fetch_nxt", int'(fetch_nxt), int'(e_fnx));
        cmp("R7", "pc_inc", int'(pc_inc), int'(e_fop || (e_fnx && need_byte)));
        cmp("R9", "xstb_n", int'(xstb_n), int'(!(kind == 2 && s <= 5)));
    endtask

    // mode: 0 internal, 1 external, 2 random mode; reqp = request probability in percent
    task automatic run(input int n, input int mode, input int reqp, input string rtag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5;
            check_all(rtag);
            ext_prog  = (mode == 2) ? 1'($urandom_range(0, 1)) : 1'(mode);
            need_byte = 1'($urandom_range(0, 1));
            xdata_req = ($urandom_range(0, 99) < reqp);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        ext_prog = 1'b1;
        #0.5;
        check_all("R1");
        cmp("R1", "psen_n in reset", int'(psen_n), 1);
        cmp("R1", "ale in reset", int'(ale), 0);
        cmp("R1", "xstb_n in reset", int'(xstb_n), 1);
        rst = 1'b0;
        @(negedge clk);
        #0.5;
        cmp("R1", "psen_n first slot", int'(psen_n), 1);
        cmp("R1", "state_idx first slot", int'(state_idx), 1);
        check_all("R1");
        run(240, 0, 0, "R2");
        run(240, 1, 0, "R5");
        // held request: back-to-back transfers, requests ignored inside first cycle
        run(240, 1, 100, "R8");
        run(240, 0, 100, "R8");
        run(1200, 2, 20, "R8");
        run(1200, 1, 40, "R9");
        // reset in the middle of a transfer
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #0.5;
        check_all("R1");
        rst = 1'b0;
        run(600, 2, 30, "R2");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule